// File: doc/BRIEF.md
# UART Receive Line Status Unit

This unit sits directly behind a UART receive shift register. Each time the shift register completes a character, the unit stores the data byte in a receive queue, together with three error tags for that character: line break, bad stop bit (framing) and bad parity. The CPU drains the queue through a data-register read strobe and sees the head character on `head_data`.

A line status word reports four things:
- whether data is waiting;
- an overrun condition, raised as soon as a character arrives at a full queue (that character is dropped);
- the break, framing and parity tags, taken from the character at the head of the queue rather than from the newest arrival.

The error bits are sticky. They clear only when the CPU reads the status word. When the enable input is high, any set error bit drives the receiver line status interrupt.

Queue occupancy is tracked by a three-state machine: `FILL_EMPTY`, `FILL_PARTIAL` and `FILL_FULL`. The transitions are:
- first push: `FILL_EMPTY` to `FILL_PARTIAL`;
- fill: `FILL_PARTIAL` to `FILL_FULL`;
- free: `FILL_FULL` to `FILL_PARTIAL`, on a pop without a push;
- drain: `FILL_PARTIAL` to `FILL_EMPTY`, on the last pop.

A push and a pop in the same cycle leave the state unchanged. In `FILL_FULL`, an arrival without a same-cycle pop raises an overrun.

Top module: `rxstat_unit`

## Requirements
- R1: After reset, `st_ready`, `head_data` (0x00), all four error bits and `rls_irq` are 0.
- R2: `st_ready` is 1 exactly when the queue holds at least one character. It rises the cycle after a push into an empty queue and falls the cycle after the last character is popped.
- R3: The queue is first-in first-out, and `head_data` shows the oldest character. A pulse on `rd_data` pops the head. A pop while the queue is empty changes nothing, and `head_data` keeps the last character popped.
- R4: The break, framing and parity bits are set from a character's tags (`chr_tags` bit 2 = break, bit 1 = framing, bit 0 = parity) in the cycle that character becomes the head. A tagged character waiting behind another does not set them.
- R5: With 16 characters queued, a `chr_valid` pulse without a same-cycle pop sets `st_overrun` on the next cycle. The arriving character is discarded and the queue contents are unchanged.
- R6: A pulse on `rd_stat` clears the break, framing, parity and overrun bits on the next cycle.
- R7: Error bits stay set after their character leaves the head, until a status read.
- R8: `rls_irq` is 1 exactly when `rls_en` is 1 and at least one of the four error bits is set. It is 0 whenever `rls_en` is 0.
- R9: When a status read coincides with a new error event (a tagged character reaching the head, or an overrun), the new event's bit is set after that cycle.
- R10: When the queue is full, a push and a pop in the same cycle are both accepted, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_valid | input | 1 | Character-complete strobe from the shift register |
| chr_data | input | 8 | Received data byte |
| chr_tags | input | 3 | Per-character error tags: bit 2 = break, bit 1 = framing, bit 0 = parity |
| rd_data | input | 1 | CPU data-register read strobe (pops the head) |
| rd_stat | input | 1 | CPU status-register read strobe |
| rls_en | input | 1 | Line status interrupt enable |
| head_data | output | 8 | Head character, or the last popped character when the queue is empty |
| st_ready | output | 1 | Data waiting |
| st_overrun | output | 1 | Overrun error |
| st_parity | output | 1 | Parity error of the head character (sticky) |
| st_framing | output | 1 | Framing error of the head character (sticky) |
| st_break | output | 1 | Break seen on the head character (sticky) |
| rls_irq | output | 1 | Receiver line status interrupt |

## Verification
Two events can fall in one cycle and create a priority question.

- **Status read against a new error.** A status read that lands in the same cycle as a break-tagged character entering an empty queue is judged by the break bit: it must be set afterwards. A status read that lands in the same cycle as a second arrival at a full queue is judged by the overrun bit, which must stay high.
- **Push against pop at a full queue.** The bench drives both in one cycle at the full queue. It then checks that no overrun is raised, and that a full drain returns the new character last, after the 15 survivors and with the dropped characters absent.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    // Error tags carried with each queued character
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } err_tags_t;

    // Occupancy of the receive queue
    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_state_t;

endpackage

// File: rtl/rxstat_fifo.sv
module rxstat_fifo
    import rxstat_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  err_tags_t         wr_tags,
    input  logic              rd_req,
    output logic [DATA_W-1:0] head_data,
    output logic              not_empty,
    output logic              ovr_evt,
    output logic              head_load,
    output err_tags_t         load_tags
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    fill_state_t       state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [PTR_W-1:0]  wptr, rptr;
    logic [DATA_W-1:0] mem_d [DEPTH];
    err_tags_t         mem_t [DEPTH];
    logic [DATA_W-1:0] last_q;
    logic              push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Output / acceptance decode per state
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        ovr_evt = 1'b0;
        unique case (state)
            FILL_EMPTY: begin
                push_ok = wr_req;
            end
            FILL_PARTIAL: begin
                push_ok = wr_req;
                pop_ok  = rd_req;
            end
            FILL_FULL: begin
                pop_ok  = rd_req;
                push_ok = wr_req && rd_req;
                ovr_evt = wr_req && !rd_req;
            end
            default: ;
        endcase
    end

    always_comb begin
        cnt_n = cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        if (cnt_n == '0)                  state_n = FILL_EMPTY;
        else if (cnt_n == CNT_W'(DEPTH))  state_n = FILL_FULL;
        else                              state_n = FILL_PARTIAL;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FILL_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            last_q <= '0;
        end else begin
            if (push_ok) wptr <= ptr_inc(wptr);
            if (pop_ok) begin
                rptr   <= ptr_inc(rptr);
                last_q <= mem_d[rptr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_d[wptr] <= wr_data;
            mem_t[wptr] <= wr_tags;
        end
    end

    // A new head appears on a push into an empty queue, on a push that
    // replaces the only entry as it pops, or on a pop that exposes the next entry
    always_comb begin
        head_load = (push_ok && (state == FILL_EMPTY || (pop_ok && cnt == CNT_W'(1))))
                 || (pop_ok && cnt > CNT_W'(1));
        load_tags = (pop_ok && cnt > CNT_W'(1)) ? mem_t[ptr_inc(rptr)] : wr_tags;
    end

    assign not_empty = (state != FILL_EMPTY);
    assign head_data = (state == FILL_EMPTY) ? last_q : mem_d[rptr];

endmodule

// File: rtl/rxstat_flags.sv
module rxstat_flags
    import rxstat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      head_load,
    input  err_tags_t load_tags,
    input  logic      ovr_evt,
    input  logic      stat_rd,
    input  logic      irq_en,
    output err_tags_t head_err,
    output logic      ovr_err,
    output logic      irq
);
    localparam int NTAG = $bits(err_tags_t);

    logic [NTAG-1:0] tag_vec;
    logic [NTAG-1:0] err_q;

    assign tag_vec = load_tags;

    // One sticky cell per head tag; a set in the read cycle wins
    for (genvar g = 0; g < NTAG; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (!rst_n)                       err_q[g] <= 1'b0;
            else if (head_load && tag_vec[g]) err_q[g] <= 1'b1;
            else if (stat_rd)                 err_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        ovr_err <= 1'b0;
        else if (ovr_evt)  ovr_err <= 1'b1;
        else if (stat_rd)  ovr_err <= 1'b0;
    end

    assign head_err = err_q;
    assign irq      = irq_en && (ovr_err || (|err_q));

endmodule

// File: rtl/rxstat_unit.sv
module rxstat_unit
    import rxstat_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic [2:0]        chr_tags,
    input  logic              rd_data,
    input  logic              rd_stat,
    input  logic              rls_en,
    output logic [DATA_W-1:0] head_data,
    output logic              st_ready,
    output logic              st_overrun,
    output logic              st_parity,
    output logic              st_framing,
    output logic              st_break,
    output logic              rls_irq
);
    err_tags_t in_tags, load_tags, head_err;
    logic      head_load, ovr_evt;

    assign in_tags = chr_tags;

    rxstat_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (chr_valid),
        .wr_data   (chr_data),
        .wr_tags   (in_tags),
        .rd_req    (rd_data),
        .head_data (head_data),
        .not_empty (st_ready),
        .ovr_evt   (ovr_evt),
        .head_load (head_load),
        .load_tags (load_tags)
    );

    rxstat_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_load (head_load),
        .load_tags (load_tags),
        .ovr_evt   (ovr_evt),
        .stat_rd   (rd_stat),
        .irq_en    (rls_en),
        .head_err  (head_err),
        .ovr_err   (st_overrun),
        .irq       (rls_irq)
    );

    assign st_break   = head_err.brk;
    assign st_framing = head_err.frm;
    assign st_parity  = head_err.par;

endmodule

// File: rtl/rxstat_unit_chk.sv
module rxstat_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chr_valid,
    input logic              rd_data,
    input logic              rd_stat,
    input logic              rls_en,
    input logic [DATA_W-1:0] head_data,
    input logic              st_ready,
    input logic              st_overrun,
    input logic              st_parity,
    input logic              st_framing,
    input logic              st_break,
    input logic              rls_irq
);
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !chr_valid && !rd_data) |=>
        !(st_break || st_framing || st_parity || st_overrun));

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !rls_en |-> !rls_irq);

    a_r8_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !chr_valid && !rd_data) |=> !rls_irq);

    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overrun && !rd_stat) |=> st_overrun);

    a_r3_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_ready && !chr_valid) |=> (!st_ready && $stable(head_data)));

    a_r2_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ready) |-> $past(chr_valid));

endmodule

bind rxstat_unit rxstat_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chr_valid  (chr_valid),
    .rd_data    (rd_data),
    .rd_stat    (rd_stat),
    .rls_en     (rls_en),
    .head_data  (head_data),
    .st_ready   (st_ready),
    .st_overrun (st_overrun),
    .st_parity  (st_parity),
    .st_framing (st_framing),
    .st_break   (st_break),
    .rls_irq    (rls_irq)
);

// File: tb/rxstat_unit_bench.sv
`timescale 1ns/1ps
module rxstat_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_valid = 1'b0;
    logic [7:0] chr_data = '0;
    logic [2:0] chr_tags = '0;
    logic       rd_data = 1'b0;
    logic       rd_stat = 1'b0;
    logic       rls_en = 1'b1;
    logic [7:0] head_data;
    logic       st_ready, st_overrun, st_parity, st_framing, st_break, rls_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rxstat_unit u_rxstat_unit (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_tags(chr_tags), .rd_data(rd_data), .rd_stat(rd_stat), .rls_en(rls_en),
        .head_data(head_data), .st_ready(st_ready), .st_overrun(st_overrun),
        .st_parity(st_parity), .st_framing(st_framing), .st_break(st_break),
        .rls_irq(rls_irq)
    );

    // {cv, data[8], tags{brk,frm,par}, rdd, rds, en, exp_rdy, exp_head[8], exp{brk,frm,par,ovr,irq}}
    localparam int NV = 13;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 8'hA1, 3'b000, 3'b001, 1'b1, 8'hA1, 5'b00000},
        {1'b1, 8'hB2, 3'b001, 3'b001, 1'b1, 8'hA1, 5'b00000},
        {1'b1, 8'hC3, 3'b010, 3'b001, 1'b1, 8'hA1, 5'b00000},
        {1'b0, 8'h00, 3'b000, 3'b101, 1'b1, 8'hB2, 5'b00101},
        {1'b0, 8'h00, 3'b000, 3'b000, 1'b1, 8'hB2, 5'b00100},
        {1'b0, 8'h00, 3'b000, 3'b101, 1'b1, 8'hC3, 5'b01101},
        {1'b0, 8'h00, 3'b000, 3'b011, 1'b1, 8'hC3, 5'b00000},
        {1'b0, 8'h00, 3'b000, 3'b101, 1'b0, 8'hC3, 5'b00000},
        {1'b0, 8'h00, 3'b000, 3'b101, 1'b0, 8'hC3, 5'b00000},
        {1'b1, 8'hD4, 3'b100, 3'b011, 1'b1, 8'hD4, 5'b10001},
        {1'b0, 8'h00, 3'b000, 3'b011, 1'b1, 8'hD4, 5'b00000},
        {1'b1, 8'hE5, 3'b000, 3'b101, 1'b1, 8'hE5, 5'b00000},
        {1'b0, 8'h00, 3'b000, 3'b101, 1'b0, 8'hE5, 5'b00000}
    };
    string VREQ [NV] = '{"R2", "R4", "R4", "R4 R8", "R8", "R7 R4", "R6",
                         "R2", "R3", "R9", "R6", "R3", "R2"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, let one rising edge pass, return at the falling edge
    task automatic step(input logic cv, input logic [7:0] d, input logic [2:0] t,
                        input logic rdd, input logic rds, input logic en);
        chr_valid = cv; chr_data = d; chr_tags = t;
        rd_data = rdd; rd_stat = rds; rls_en = en;
        @(negedge clk);
    endtask

    function automatic logic [4:0] flags();
        return {st_break, st_framing, st_parity, st_overrun, rls_irq};
    endfunction

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL all: watchdog expired actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 ready", 32'(st_ready), 32'd0);
        chk("R1 head", 32'(head_data), 32'h00);
        chk("R1 flags", 32'(flags()), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            step(v[28], v[27:20], v[19:17], v[16], v[15], v[14]);
            chk({VREQ[i], " ready"}, 32'(st_ready), 32'(v[13]));
            chk({VREQ[i], " head"},  32'(head_data), 32'(v[12:5]));
            chk({VREQ[i], " flags"}, 32'(flags()), 32'(v[4:0]));
        end

        // R5: fill all 16 entries, then overflow
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 8'(8'h10 + i), 3'b000, 1'b0, 1'b0, 1'b1);
            chk("R2 fill ready", 32'(st_ready), 32'd1);
            chk("R5 no early overrun", 32'(st_overrun), 32'd0);
        end
        chk("R3 head after fill", 32'(head_data), 32'h10);
        step(1'b1, 8'hEE, 3'b111, 1'b0, 1'b0, 1'b1);
        chk("R5 overrun set", 32'(st_overrun), 32'd1);
        chk("R5 head unchanged", 32'(head_data), 32'h10);
        chk("R8 irq on overrun", 32'(rls_irq), 32'd1);
        chk("R5 tags of dropped char ignored", 32'({st_break, st_framing, st_parity}), 32'd0);
        // R9: overrun coinciding with status read
        step(1'b1, 8'hEF, 3'b000, 1'b0, 1'b1, 1'b1);
        chk("R9 overrun wins over read", 32'(st_overrun), 32'd1);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1);
        chk("R6 overrun cleared", 32'(st_overrun), 32'd0);
        chk("R8 irq cleared", 32'(rls_irq), 32'd0);
        // R10: push with pop while full
        step(1'b1, 8'h77, 3'b000, 1'b1, 1'b0, 1'b1);
        chk("R10 no overrun", 32'(st_overrun), 32'd0);
        chk("R10 head advanced", 32'(head_data), 32'h11);
        // drain: 0x11..0x1F then 0x77; dropped characters never appear
        for (int i = 0; i < 16; i++) begin
            chk("R5 R10 drain order", 32'(head_data), (i < 15) ? 32'(8'h11 + i) : 32'h77);
            step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b1);
        end
        chk("R2 empty after drain", 32'(st_ready), 32'd0);
        chk("R3 last head kept", 32'(head_data), 32'h77);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule